// File: doc/BRIEF.md
# Paired-Issue Dependency Stall Counter

This block sits beside the issue stage of a two-wide in-order core. Two instructions fetched together form a pair, and the block decides how long the second one has to wait for the first. For each of the two it receives a class code, register masks for destinations and sources, and a precision flag. It also receives the leading instruction's latency to its last write-back. It looks for three kinds of dependency: read-after-write, write-after-write and write-after-read. Each kind gets its own class-pair rule. The stall count is the largest result among them.

When a pair strobe arrives and the block is idle, the count is loaded into a down-counter. The stall output stays high while that counter is nonzero. Pairs that arrive while a stall is running are dropped. The issue logic must present the pair again once the stall ends.

Top module: `hazard_stall_unit`

## Requirements
- R1: Each register mask has integer registers in bits [INT_REGS-1:0] and float registers in bits [INT_REGS+FLT_REGS-1:INT_REGS]. The float status register is the top bit. A read-after-write exists when lead_dst and trail_src overlap. Its stall is the lead latency after R2 to R4 are applied.
- R2: Class codes are 0 plain, 1 load, 2 float-register store, 3 other load/store, 4 register-amount shift, 5 float divide/square-root, 6 float add/sub/mul, 7 matrix-vector transform, 8 inner product, 9 other float-execute. Codes 1 to 3 form the load/store group and codes 5 to 9 form the float-execute group. For a read-after-write from a load (1) into a shift (4), the latency is raised by 1.
- R3: For a read-after-write from any float-execute lead into a float-register store (2), the latency is lowered by 1.
- R4: Take a read-after-write where the lead writes a float register and has latency below 2. If the trail has trail_dbl set, or is an inner product (8) or a transform (7), the latency becomes 2.
- R5: A write-after-write is counted only when a float-execute lead and a load/store trail share a destination. Its stall is latency−1 for a divide/square-root lead and latency−2 for any other float-execute lead, never below 0.
- R6: A shared destination on the status bit alone never gives a write-after-write stall.
- R7: A write-after-read exists when lead_src and trail_dst overlap. It stalls 5 for a transform lead and 2 for an add/sub/mul lead with lead_dbl set. For any other lead it stalls 0.
- R8: When several dependencies apply, the stall is the largest of their counts.
- R9: If pair_valid is high while remaining is 0, then remaining and last_count both take the stall count at the next edge. remaining then decrements once per cycle, and stall is high exactly while remaining is nonzero.
- R10: While remaining is nonzero, pair_valid has no effect on remaining or last_count.
- R11: A pair with no mask overlap of any kind gives a count of 0, and stall stays low on the next cycle.
- R12: Synchronous reset clears stall, remaining and last_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_valid | input | 1 | Issue-pair strobe |
| lead_class | input | 4 | Class code of the earlier instruction |
| lead_dst | input | INT_REGS+FLT_REGS+1 | Destination mask of the earlier instruction |
| lead_src | input | INT_REGS+FLT_REGS+1 | Source mask of the earlier instruction |
| lead_lat | input | LAT_W | Longest latency to final write-back of the earlier instruction |
| lead_dbl | input | 1 | Earlier instruction is double precision |
| trail_class | input | 4 | Class code of the later instruction |
| trail_dst | input | INT_REGS+FLT_REGS+1 | Destination mask of the later instruction |
| trail_src | input | INT_REGS+FLT_REGS+1 | Source mask of the later instruction |
| trail_dbl | input | 1 | Later instruction is double precision |
| stall | output | 1 | Hold the later instruction |
| remaining | output | LAT_W+1 | Stall cycles still to run |
| last_count | output | LAT_W+1 | Count loaded by the last accepted pair |

## Verification
Directed pairs test each class-pair rule by itself. Load into shift, float compute into store, and short float latency into a double-precision consumer each distinguish an adjusted latency from the plain one. Write-after-write is tried with a divide lead, an arithmetic lead, a non-float lead and a status-only overlap, which separates the −1, −2, zero and excluded cases. The combined pairs check that the largest count wins, not the first or the sum. A strobe sent during a running stall shows whether it was dropped. Random sparse masks then mix all the rules, including pairs with no dependency.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [3:0] {
    CL_PLAIN   = 4'd0,
    CL_LOAD    = 4'd1,
    CL_FSTORE  = 4'd2,
    CL_LSOTHER = 4'd3,
    CL_SHIFT   = 4'd4,
    CL_FDIVSQ  = 4'd5,
    CL_FARITH  = 4'd6,
    CL_FXFORM  = 4'd7,
    CL_FINNER  = 4'd8,
    CL_FOTHER  = 4'd9
  } cls_e;

  function automatic logic is_fe(input logic [3:0] c);
    return (c >= 4'd5) && (c <= 4'd9);
  endfunction

  function automatic logic is_ls(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd3);
  endfunction
endpackage

// File: rtl/hz_rules.sv
module hz_rules #(
  parameter int INT_REGS = 16,
  parameter int FLT_REGS = 16,
  parameter int LAT_W    = 6,
  localparam int MW = INT_REGS + FLT_REGS + 1,
  localparam int CW = LAT_W + 1
) (
  input  logic [3:0]       lead_class,
  input  logic [MW-1:0]    lead_dst,
  input  logic [MW-1:0]    lead_src,
  input  logic [LAT_W-1:0] lead_lat,
  input  logic             lead_dbl,
  input  logic [3:0]       trail_class,
  input  logic [MW-1:0]    trail_dst,
  input  logic [MW-1:0]    trail_src,
  input  logic             trail_dbl,
  output logic [CW-1:0]    count
);
  import hz_pkg::*;
  localparam int SW = LAT_W + 3;

  logic [MW-1:0] waw_mask;
  logic raw_hit, waw_hit, war_hit, lead_wr_flt;
  logic signed [SW-1:0] base, raw_v, waw_v, war_v, best;

  assign waw_mask    = {1'b0, {(MW-1){1'b1}}};
  assign raw_hit     = |(lead_dst & trail_src);
  assign war_hit     = |(lead_src & trail_dst);
  assign waw_hit     = is_fe(lead_class) && is_ls(trail_class) &&
                       (|(lead_dst & trail_dst & waw_mask));
  assign lead_wr_flt = |lead_dst[INT_REGS +: FLT_REGS];
  assign base        = signed'({3'b000, lead_lat});

  always_comb begin
    raw_v = '0;
    if (raw_hit) begin
      raw_v = base;
      if (lead_class == CL_LOAD && trail_class == CL_SHIFT)
        raw_v = raw_v + SW'(1);
      if (is_fe(lead_class) && trail_class == CL_FSTORE)
        raw_v = raw_v - SW'(1);
      if (lead_wr_flt && (raw_v < SW'(2)) &&
          (trail_dbl || trail_class == CL_FINNER || trail_class == CL_FXFORM))
        raw_v = SW'(2);
    end
    if (raw_v < 0) raw_v = '0;
  end

  always_comb begin
    waw_v = '0;
    if (waw_hit)
      waw_v = (lead_class == CL_FDIVSQ) ? base - SW'(1) : base - SW'(2);
    if (waw_v < 0) waw_v = '0;
  end

  always_comb begin
    war_v = '0;
    if (war_hit) begin
      if (lead_class == CL_FXFORM)                 war_v = SW'(5);
      else if (lead_class == CL_FARITH && lead_dbl) war_v = SW'(2);
    end
  end

  always_comb begin
    best = raw_v;
    if (waw_v > best) best = waw_v;
    if (war_v > best) best = war_v;
  end

  assign count = best[CW-1:0];
endmodule

// File: rtl/hz_countdown.sv
module hz_countdown #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_req,
  input  logic [CW-1:0] load_val,
  output logic          stall,
  output logic [CW-1:0] remaining,
  output logic [CW-1:0] last_count
);
  logic [CW-1:0] cnt_nxt;
  logic          accept;

  assign accept = load_req && (remaining == '0);

  always_comb begin
    if (remaining != '0) cnt_nxt = remaining - CW'(1);
    else if (accept)     cnt_nxt = load_val;
    else                 cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining  <= '0;
      last_count <= '0;
      stall      <= 1'b0;
    end else begin
      remaining <= cnt_nxt;
      stall     <= (cnt_nxt != '0);
      if (accept) last_count <= load_val;
    end
  end
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit #(
  parameter int INT_REGS = 16,
  parameter int FLT_REGS = 16,
  parameter int LAT_W    = 6,
  localparam int MW = INT_REGS + FLT_REGS + 1,
  localparam int CW = LAT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pair_valid,
  input  logic [3:0]       lead_class,
  input  logic [MW-1:0]    lead_dst,
  input  logic [MW-1:0]    lead_src,
  input  logic [LAT_W-1:0] lead_lat,
  input  logic             lead_dbl,
  input  logic [3:0]       trail_class,
  input  logic [MW-1:0]    trail_dst,
  input  logic [MW-1:0]    trail_src,
  input  logic             trail_dbl,
  output logic             stall,
  output logic [CW-1:0]    remaining,
  output logic [CW-1:0]    last_count
);
  logic [CW-1:0] pair_count;

  hz_rules #(.INT_REGS(INT_REGS), .FLT_REGS(FLT_REGS), .LAT_W(LAT_W)) u_rules (
    .lead_class (lead_class),
    .lead_dst   (lead_dst),
    .lead_src   (lead_src),
    .lead_lat   (lead_lat),
    .lead_dbl   (lead_dbl),
    .trail_class(trail_class),
    .trail_dst  (trail_dst),
    .trail_src  (trail_src),
    .trail_dbl  (trail_dbl),
    .count      (pair_count)
  );

  hz_countdown #(.CW(CW)) u_count (
    .clk       (clk),
    .rst       (rst),
    .load_req  (pair_valid),
    .load_val  (pair_count),
    .stall     (stall),
    .remaining (remaining),
    .last_count(last_count)
  );
endmodule

// File: rtl/hz_stall_checker.sv
module hz_stall_checker #(
  parameter int MW = 33,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          pair_valid,
  input logic [MW-1:0] lead_dst,
  input logic [MW-1:0] lead_src,
  input logic [MW-1:0] trail_dst,
  input logic [MW-1:0] trail_src,
  input logic          stall,
  input logic [CW-1:0] remaining,
  input logic [CW-1:0] last_count
);
  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && remaining == '0) |=> (remaining == last_count));

  p_stall_level_r9: assert property (@(posedge clk) disable iff (rst)
    stall == (remaining != '0));

  p_busy_decrement_r10: assert property (@(posedge clk) disable iff (rst)
    (remaining != '0) |=> (remaining == $past(remaining) - CW'(1)));

  p_busy_keeps_last_r10: assert property (@(posedge clk) disable iff (rst)
    (remaining != '0) |=> $stable(last_count));

  p_no_dep_r11: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && remaining == '0 && ((lead_dst & trail_src) == '0) &&
     ((lead_src & trail_dst) == '0) && ((lead_dst & trail_dst) == '0)) |=> !stall);

  p_idle_stays_r9: assert property (@(posedge clk) disable iff (rst)
    (!pair_valid && remaining == '0) |=> !stall);
endmodule

bind hazard_stall_unit hz_stall_checker #(.MW(MW), .CW(CW)) i_hz_chk (
  .clk       (clk),
  .rst       (rst),
  .pair_valid(pair_valid),
  .lead_dst  (lead_dst),
  .lead_src  (lead_src),
  .trail_dst (trail_dst),
  .trail_src (trail_src),
  .stall     (stall),
  .remaining (remaining),
  .last_count(last_count)
);

// File: tb/test_hazard_stall_unit.sv
`timescale 1ns/1ps
module test_hazard_stall_unit;
  localparam int IR = 16, FR = 16, LW = 6;
  localparam int MW = IR + FR + 1, CW = LW + 1;

  logic clk = 1'b0, rst = 1'b1, pair_valid = 1'b0;
  logic [3:0] lead_class = '0, trail_class = '0;
  logic [MW-1:0] lead_dst = '0, lead_src = '0, trail_dst = '0, trail_src = '0;
  logic [LW-1:0] lead_lat = '0;
  logic lead_dbl = 1'b0, trail_dbl = 1'b0;
  logic stall;
  logic [CW-1:0] remaining, last_count;

  int vectors = 0, errors = 0;
  int m_rem = 0, m_last = 0;

  always #4 clk = ~clk;

  hazard_stall_unit #(.INT_REGS(IR), .FLT_REGS(FR), .LAT_W(LW)) i_hazard_stall_unit (
    .clk(clk), .rst(rst), .pair_valid(pair_valid),
    .lead_class(lead_class), .lead_dst(lead_dst), .lead_src(lead_src),
    .lead_lat(lead_lat), .lead_dbl(lead_dbl),
    .trail_class(trail_class), .trail_dst(trail_dst), .trail_src(trail_src),
    .trail_dbl(trail_dbl),
    .stall(stall), .remaining(remaining), .last_count(last_count)
  );

  function automatic logic [MW-1:0] ireg(input int n); return MW'(1) << n;      endfunction
  function automatic logic [MW-1:0] freg(input int n); return MW'(1) << (IR+n); endfunction
  function automatic logic [MW-1:0] sreg();            return MW'(1) << (MW-1); endfunction

  // expected count straight from the requirement text
  function automatic int expect_count();
    int raw = 0, waw = 0, war = 0, r;
    bit fe_lead = (lead_class >= 5 && lead_class <= 9);
    bit ls_trail = (trail_class >= 1 && trail_class <= 3);
    logic [MW-1:0] both_dst = lead_dst & trail_dst;
    both_dst[MW-1] = 1'b0;
    if ((lead_dst & trail_src) != 0) begin
      raw = lead_lat;
      if (lead_class == 1 && trail_class == 4) raw++;
      if (fe_lead && trail_class == 2) raw--;
      if ((lead_dst[IR +: FR] != 0) && raw < 2 &&
          (trail_dbl || trail_class == 8 || trail_class == 7)) raw = 2;
      if (raw < 0) raw = 0;
    end
    if (fe_lead && ls_trail && both_dst != 0) begin
      waw = (lead_class == 5) ? int'(lead_lat) - 1 : int'(lead_lat) - 2;
      if (waw < 0) waw = 0;
    end
    if ((lead_src & trail_dst) != 0) begin
      if (lead_class == 7) war = 5;
      else if (lead_class == 6 && lead_dbl) war = 2;
    end
    r = raw;
    if (waw > r) r = waw;
    if (war > r) r = war;
    return r;
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (stall !== (m_rem != 0) || int'(remaining) != m_rem || int'(last_count) != m_last) begin
      errors++;
      $display("FAIL %s: stall=%0b remaining=%0d last=%0d expected stall=%0b remaining=%0d last=%0d",
               tag, stall, remaining, last_count, (m_rem != 0), m_rem, m_last);
    end
  endtask

  // drive at negedge, model the posedge, compare at next negedge
  task automatic step(input string tag, input bit v, input int lc, input logic [MW-1:0] ld,
                      input logic [MW-1:0] ls, input int lat, input bit ldb, input int tc,
                      input logic [MW-1:0] td, input logic [MW-1:0] ts, input bit tdb);
    pair_valid = v; lead_class = 4'(lc); lead_dst = ld; lead_src = ls;
    lead_lat = LW'(lat); lead_dbl = ldb; trail_class = 4'(tc);
    trail_dst = td; trail_src = ts; trail_dbl = tdb;
    @(posedge clk);
    if (m_rem != 0) m_rem--;
    else if (v) begin m_rem = expect_count(); m_last = m_rem; end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, '0, '0, 0, 0, 0, '0, '0, 0);
  endtask

  task automatic pair(input string tag, input int lc, input logic [MW-1:0] ld,
                      input logic [MW-1:0] ls, input int lat, input bit ldb, input int tc,
                      input logic [MW-1:0] td, input logic [MW-1:0] ts, input bit tdb);
    step(tag, 1, lc, ld, ls, lat, ldb, tc, td, ts, tdb);
    idle(tag, m_rem + 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    compare("R12 reset");
    // R1 plain read-after-write
    pair("R1 raw", 0, ireg(1), '0, 3, 0, 0, '0, ireg(1), 0);
    // R11 no overlap
    pair("R11 none", 6, freg(1), freg(2), 9, 1, 1, freg(3), freg(4), 1);
    // R2 load feeding shift
    pair("R2 load-shift", 1, ireg(2), '0, 2, 0, 4, '0, ireg(2), 0);
    // R3 float compute into store
    pair("R3 fe-store", 6, freg(1), '0, 4, 0, 2, '0, freg(1), 0);
    // R4 short latency into double / inner / transform
    pair("R4 dbl", 9, freg(2), '0, 1, 0, 0, '0, freg(2), 1);
    pair("R4 inner", 9, freg(2), '0, 0, 0, 8, '0, freg(2), 0);
    pair("R4 xform", 0, freg(2), '0, 1, 0, 7, '0, freg(2), 0);
    // R5 write-after-write
    pair("R5 divsqrt", 5, freg(3), '0, 10, 0, 1, freg(3), '0, 0);
    pair("R5 arith", 6, freg(3), '0, 6, 0, 3, freg(3), '0, 0);
    pair("R5 clamp", 6, freg(3), '0, 1, 0, 3, freg(3), '0, 0);
    pair("R5 non-fe lead", 0, freg(3), '0, 6, 0, 1, freg(3), '0, 0);
    // R6 status only
    pair("R6 status", 6, sreg(), '0, 6, 0, 3, sreg(), '0, 0);
    // R7 write-after-read
    pair("R7 xform", 7, freg(5), freg(4), 1, 0, 0, freg(4), '0, 0);
    pair("R7 dbl arith", 6, freg(7), freg(6), 1, 1, 0, freg(6), '0, 0);
    pair("R7 single", 6, freg(7), freg(6), 1, 0, 0, freg(6), '0, 0);
    // R8 maximum of several
    pair("R8 war wins", 7, freg(7), freg(8), 3, 0, 1, freg(7) | freg(8), '0, 0);
    pair("R8 raw wins", 6, freg(9), '0, 7, 0, 2, freg(9), freg(9), 0);
    // R10 strobe during stall
    step("R10 start", 1, 0, ireg(3), '0, 6, 0, 0, '0, ireg(3), 0);
    step("R10 ignored", 1, 0, ireg(4), '0, 20, 0, 0, '0, ireg(4), 0);
    step("R10 ignored", 1, 7, freg(1), freg(2), 30, 0, 0, freg(2), freg(1), 0);
    idle("R10 drain", 6);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [MW-1:0] a, b, c, d;
      a = MW'(1) << $urandom_range(MW-1); b = MW'(1) << $urandom_range(MW-1);
      c = MW'(1) << $urandom_range(MW-1); d = MW'(1) << $urandom_range(MW-1);
      if ($urandom_range(1)) a = a | freg($urandom_range(3));
      if ($urandom_range(1)) c = c | freg($urandom_range(3));
      step("R8 random", $urandom_range(3) != 0, $urandom_range(9), a, b,
           $urandom_range(20), $urandom_range(1), $urandom_range(9), c, d, $urandom_range(1));
    end
    idle("R9 final", 40);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule